// File: doc/BRIEF.md
# Processor Status Word with Flag Generation

This block holds the 16-bit status word of a processor with a byte/word ALU. After each ALU operation it takes the operands, the result, an operation class and a byte/word width select. From these it derives the arithmetic status bits: carry, parity, auxiliary carry, zero, sign and overflow. The ALU datapath stays outside the block. The flag logic reads the result the ALU already produced, plus the operand bits it needs, and works out the carries from them.

The word also holds three control bits: single-step enable, interrupt enable and string direction. Each of these can be set or cleared on its own. The whole word can also be loaded in one go, as after a restore from the stack. The direction bit is brought out separately, so that string address registers know whether to step down or up after each element.

All updates take effect at the rising clock edge in which they are presented. The reset input is asynchronous and active low, and it is released through a two-flop synchronizer. The word therefore first accepts an update two rising edges after `rst_n` goes high.

Top module: `flagword_top`

## Requirements
- R1: While reset is active, and after it is released, the word reads 0x0002, with interrupts disabled (bit 9 = 0) and `dir_down` = 0.
- R2: The reserved bits never change and ignore every write: bit 1 always reads 1, and bits 3, 5 and 15..12 always read 0.
- R3: When `wr_en` is 1, the word becomes `(wr_data & 0x0FD5) | 0x0002` on the next edge. This load takes priority over every other update presented in the same cycle.
- R4: On an arithmetic update, the zero bit (bit 6) is set when the result is zero over the selected width. The sign bit (bit 7) takes the top bit of that width: result bit 7 when `wsel` = 0 (byte) and result bit 15 when `wsel` = 1 (word).
- R5: On an arithmetic update, the parity bit (bit 2) is set when result bits 7..0 hold an even number of ones. This holds for both widths.
- R6: Class 0 (add): bit 0 = carry out of the top bit, bit 4 = carry from bit 3 into bit 4, bit 11 = signed overflow.
- R7: Class 1 (subtract, a − b): bit 0 = borrow out of the top bit, bit 4 = borrow out of the low nibble, bit 11 = signed overflow.
- R8: Class 2 (logic): bits 0, 4 and 11 are cleared. Bits 2, 6 and 7 follow R4 and R5.
- R9: Classes 3 (increment a) and 4 (decrement a): operand b is ignored and a step of one is used. Bits 2, 4, 6, 7 and 11 update as for an add or a subtract of one. Carry (bit 0) is left unchanged.
- R10: When `ctl_we` is 1, the bit picked by `ctl_sel` takes the value of `ctl_val`: select 0 = bit 8 (single-step), 1 = bit 9 (interrupt enable), 2 = bit 10 (direction). Select 3 has no effect. A control update and an arithmetic update in the same cycle both take effect.
- R11: `dir_down` always equals bit 10 (1 = step down, 0 = step up).
- R12: With no enable active, or with `upd_en` and a class code of 5 to 7, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Apply the arithmetic flags of the current operation |
| opc | input | 3 | Operation class: 0 add, 1 sub, 2 logic, 3 inc, 4 dec |
| wsel | input | 1 | Width: 0 byte, 1 word |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | ALU result |
| ctl_we | input | 1 | Control-bit write strobe |
| ctl_sel | input | 2 | Control bit select |
| ctl_val | input | 1 | Value for the selected control bit |
| wr_en | input | 1 | Whole-word load |
| wr_data | input | 16 | Word to load |
| flags_q | output | 16 | Current status word |
| dir_down | output | 1 | String direction: 1 = step down |

## Verification
Adds and subtracts are driven at both widths on operand pairs chosen for each effect. Some wrap to zero, some cross the signed limit, some carry only out of the low nibble, and some leave junk in the upper byte during byte operations. These cases tell apart a wrong top-bit selection, a nibble carry taken from the wrong bit, and parity taken over the full word. Increment and decrement run with carry preset, which shows whether carry is held or overwritten. Logic operations run after a carry and overflow have been set, which shows that both are cleared. Control writes are presented alone, together with arithmetic updates and together with a word load, which exposes the priority between them. A long run of random operations then covers the classes against each other.

// File: rtl/flagword_pkg.sv
package flagword_pkg;
  localparam int FLAG_W = 16;

  localparam int BIT_CF = 0;
  localparam int BIT_PF = 2;
  localparam int BIT_AF = 4;
  localparam int BIT_ZF = 6;
  localparam int BIT_SF = 7;
  localparam int BIT_TF = 8;
  localparam int BIT_IF = 9;
  localparam int BIT_DF = 10;
  localparam int BIT_OF = 11;

  localparam logic [FLAG_W-1:0] DEF_MASK   = 16'h0FD5;
  localparam logic [FLAG_W-1:0] FIXED_ONES = 16'h0002;

  localparam logic [2:0] OPC_ADD = 3'd0;
  localparam logic [2:0] OPC_SUB = 3'd1;
  localparam logic [2:0] OPC_LOG = 3'd2;
  localparam logic [2:0] OPC_INC = 3'd3;
  localparam logic [2:0] OPC_DEC = 3'd4;

  localparam logic [1:0] SEL_TF = 2'd0;
  localparam logic [1:0] SEL_IF = 2'd1;
  localparam logic [1:0] SEL_DF = 2'd2;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } arith_t;
endpackage

// File: rtl/flagword_gen.sv
module flagword_gen
  import flagword_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]    opc,
  input  logic          wsel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] r,
  output arith_t        fl,
  output logic          hit,
  output logic          keep_cf
);
  localparam int BW    = DW / 2;
  localparam int NLANE = DW / BW;
  localparam int PBITS = 8;
  localparam int NIB   = 4;

  logic [DW-1:0]    bop;
  logic [DW-1:0]    cx;
  logic [NLANE-1:0] lane_zero;
  logic             is_sub, is_step, am, bm, rm, zres;

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      assign lane_zero[g] = (r[g*BW +: BW] == '0);
    end
  endgenerate

  always_comb begin
    is_step = (opc == OPC_INC) || (opc == OPC_DEC);
    is_sub  = (opc == OPC_SUB) || (opc == OPC_DEC);
    bop     = is_step ? DW'(1) : b;
    cx      = a ^ bop ^ r;
    am      = wsel ? a[DW-1]   : a[BW-1];
    bm      = wsel ? bop[DW-1] : bop[BW-1];
    rm      = wsel ? r[DW-1]   : r[BW-1];
    zres    = wsel ? (&lane_zero) : lane_zero[0];

    fl.zf = zres;
    fl.sf = rm;
    fl.pf = ~(^r[PBITS-1:0]);
    fl.af = cx[NIB];
    if (is_sub) begin
      fl.cf = (~am & bm) | (~(am ^ bm) & rm);
      fl.of = (am ^ bm) & (rm ^ am);
    end else begin
      fl.cf = (am & bm) | ((am ^ bm) & ~rm);
      fl.of = ~(am ^ bm) & (rm ^ am);
    end
    if (opc == OPC_LOG) begin
      fl.cf = 1'b0;
      fl.af = 1'b0;
      fl.of = 1'b0;
    end
    hit     = (opc <= OPC_DEC);
    keep_cf = is_step;
  end
endmodule

// File: rtl/flagword_next.sv
module flagword_next
  import flagword_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  logic              upd_en,
  input  logic              hit,
  input  logic              keep_cf,
  input  arith_t            fl,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_sel,
  input  logic              ctl_val,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] nxt,
  output logic              en
);
  logic [FLAG_W-1:0] work;
  logic              arith_go, ctl_go;

  always_comb begin
    arith_go = upd_en & hit;
    ctl_go   = ctl_we & (ctl_sel != 2'd3);
    work     = cur;
    if (arith_go) begin
      if (!keep_cf) work[BIT_CF] = fl.cf;
      work[BIT_PF] = fl.pf;
      work[BIT_AF] = fl.af;
      work[BIT_ZF] = fl.zf;
      work[BIT_SF] = fl.sf;
      work[BIT_OF] = fl.of;
    end
    if (ctl_go) begin
      unique case (ctl_sel)
        SEL_TF:  work[BIT_TF] = ctl_val;
        SEL_IF:  work[BIT_IF] = ctl_val;
        SEL_DF:  work[BIT_DF] = ctl_val;
        default: work = work;
      endcase
    end
    if (wr_en) work = wr_data;
    nxt = (work & DEF_MASK) | FIXED_ONES;
    en  = arith_go | ctl_go | wr_en;
  end
endmodule

// File: rtl/flagword_top.sv
module flagword_top
  import flagword_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [2:0]        opc,
  input  logic              wsel,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic [DW-1:0]     res,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_sel,
  input  logic              ctl_val,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags_q,
  output logic              dir_down
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rsync;
  logic              rst_int_n;
  logic [FLAG_W-1:0] word_q, word_d;
  logic              word_en, hit, keep_cf;
  arith_t            fl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rsync[SYNC_N-1];

  flagword_gen #(.DW(DW)) u_gen (
    .opc(opc), .wsel(wsel), .a(opa), .b(opb), .r(res),
    .fl(fl), .hit(hit), .keep_cf(keep_cf)
  );

  flagword_next u_next (
    .cur(word_q), .upd_en(upd_en), .hit(hit), .keep_cf(keep_cf), .fl(fl),
    .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_val(ctl_val),
    .wr_en(wr_en), .wr_data(wr_data), .nxt(word_d), .en(word_en)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   word_q <= FIXED_ONES;
    else if (word_en) word_q <= word_d;
  end

  assign flags_q  = word_q;
  assign dir_down = word_q[BIT_DF];
endmodule

// File: rtl/flagword_chk.sv
module flagword_chk
  import flagword_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_en,
  input logic [2:0]        opc,
  input logic              wsel,
  input logic [DW-1:0]     res,
  input logic              ctl_we,
  input logic [1:0]        ctl_sel,
  input logic              ctl_val,
  input logic              wr_en,
  input logic [FLAG_W-1:0] wr_data,
  input logic [FLAG_W-1:0] flags_q,
  input logic              dir_down
);
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[1] && !flags_q[3] && !flags_q[5] && (flags_q[15:12] == 4'h0));

  a_r3_word_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> flags_q == (($past(wr_data) & DEF_MASK) | FIXED_ONES));

  a_r4_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && opc <= OPC_DEC && wsel && res == '0) |=> flags_q[BIT_ZF]);

  a_r8_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && opc == OPC_LOG) |=> (!flags_q[BIT_CF] && !flags_q[BIT_OF]));

  a_r9_step_keeps_cf: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && (opc == OPC_INC || opc == OPC_DEC))
      |=> flags_q[BIT_CF] == $past(flags_q[BIT_CF]));

  a_r10_trap_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !wr_en && ctl_sel == SEL_TF) |=> flags_q[BIT_TF] == $past(ctl_val));

  a_r11_dir_out: assert property (@(posedge clk) disable iff (!rst_n)
    dir_down == flags_q[BIT_DF]);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !ctl_we && !wr_en) |=> $stable(flags_q));
endmodule

bind flagword_top flagword_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .upd_en(upd_en), .opc(opc), .wsel(wsel),
  .res(res), .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_val(ctl_val),
  .wr_en(wr_en), .wr_data(wr_data), .flags_q(flags_q), .dir_down(dir_down)
);

// File: tb/flagword_top_bench.sv
`timescale 1ns/1ps
module flagword_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en, wsel, ctl_we, ctl_val, wr_en;
  logic [2:0]  opc;
  logic [1:0]  ctl_sel;
  logic [15:0] opa, opb, res, wr_data;
  logic [15:0] flags_q;
  logic        dir_down;

  int    n_chk = 0;
  int    n_bad = 0;
  int    mf    = 2;
  string req   = "R1";

  always #5 clk = ~clk;

  flagword_top u_flagword_top (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .opc(opc), .wsel(wsel),
    .opa(opa), .opb(opb), .res(res), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
    .ctl_val(ctl_val), .wr_en(wr_en), .wr_data(wr_data),
    .flags_q(flags_q), .dir_down(dir_down)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    upd_en = 0; opc = 0; wsel = 1; opa = 0; opb = 0; res = 0;
    ctl_we = 0; ctl_sel = 0; ctl_val = 0; wr_en = 0; wr_data = 0;
  endtask

  function automatic int sgn(int x, int m);
    return (x > (m >> 1)) ? x - (m + 1) : x;
  endfunction

  task automatic model();
    int nv, m, h, ua, ub, ur, sa, sb, s, c, af, ov;
    nv = mf;
    if (wr_en) nv = (int'(wr_data) & 'h0FD5) | 2;
    else begin
      m = wsel ? 'hFFFF : 'hFF;
      h = (m + 1) / 2;
      ua = int'(opa) & m; ub = int'(opb) & m; ur = int'(res) & m;
      sa = sgn(ua, m); sb = sgn(ub, m);
      if (upd_en && opc <= 4) begin
        c = nv & 1; af = 0; ov = 0;
        case (opc)
          0: begin c = ((ua + ub) > m); af = (((ua & 15) + (ub & 15)) > 15);
                   s = sa + sb; ov = (s >= h || s < -h); end
          1: begin c = (ua < ub); af = ((ua & 15) < (ub & 15));
                   s = sa - sb; ov = (s >= h || s < -h); end
          3: begin af = ((ua & 15) == 15); ov = (ua == h - 1); end
          4: begin af = ((ua & 15) == 0); ov = (ua == h); end
          default: begin c = 0; af = 0; ov = 0; end
        endcase
        nv = nv & ~('h0001 | 'h0004 | 'h0010 | 'h0040 | 'h0080 | 'h0800);
        if (c != 0) nv |= 'h0001;
        if (($countones(int'(res) & 255) % 2) == 0) nv |= 'h0004;
        if (af != 0) nv |= 'h0010;
        if (ur == 0) nv |= 'h0040;
        if (ur >= h) nv |= 'h0080;
        if (ov != 0) nv |= 'h0800;
      end
      if (ctl_we && ctl_sel != 3) begin
        nv = nv & ~(1 << (8 + ctl_sel));
        if (ctl_val) nv |= (1 << (8 + ctl_sel));
      end
    end
    mf = nv;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    check({req, " word"}, int'(flags_q), mf);
    check({"R11 dir_down"}, int'(dir_down), (mf >> 10) & 1);
    idle_inputs();
  endtask

  task automatic op(int c, int w, int a, int b);
    int m, r;
    m = w ? 'hFFFF : 'hFF;
    case (c)
      0: r = a + b;
      1: r = a - b;
      2: r = a & b;
      3: r = a + 1;
      4: r = a - 1;
      default: r = a;
    endcase
    upd_en = 1; opc = 3'(c); wsel = w[0]; opa = 16'(a); opb = 16'(b);
    res = w ? 16'(r) : 16'((a & 'hFF00) | (r & m));
    step();
  endtask

  task automatic load(int v);
    wr_en = 1; wr_data = 16'(v); step();
  endtask

  task automatic ctl(int s, int v);
    ctl_we = 1; ctl_sel = 2'(s); ctl_val = v[0]; step();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    req = "R1";
    check("R1 reset word", int'(flags_q), 'h0002);
    check("R1 reset dir", int'(dir_down), 0);
    rst_n = 1;
    repeat (3) step();
    check("R1 after release", int'(flags_q), 'h0002);

    req = "R3"; load('hFFFF);
    check("R2 fixed bits after all-ones load", int'(flags_q), 'h0FD7);
    req = "R2"; load('hF02A);
    check("R2 reserved ignore", int'(flags_q), 'h0002);
    req = "R3"; load('h0000);

    req = "R6";
    op(0, 1, 'hFFFF, 'h0001);
    check("R6 word wrap cf/zf/af/pf", int'(flags_q), 'h0057);
    op(0, 1, 'h7FFF, 'h0001);
    check("R6 word overflow", int'(flags_q), 'h0896);
    op(0, 1, 'h1234, 'h1111);
    op(0, 0, 'hA5FF, 'h0001);
    req = "R4"; op(0, 0, 'h127F, 'h0001);
    check("R4 byte sign/overflow", int'(flags_q), 'h0892);
    op(0, 0, 'hFF0F, 'h0001);
    req = "R5"; op(0, 1, 'h0100, 'h0002);
    op(0, 1, 'h0180, 'h0000);

    req = "R7";
    op(1, 1, 'h0000, 'h0001);
    op(1, 1, 'h8000, 'h0001);
    check("R7 word signed overflow", int'(flags_q), 'h0816);
    op(1, 1, 'h0005, 'h0005);
    op(1, 0, 'h3380, 'h0001);
    op(1, 0, 'h0010, 'h0001);

    req = "R8";
    op(0, 1, 'h8000, 'h8000);
    op(2, 1, 'hF0F0, 'hFFFF);
    check("R8 logic clears cf/of", int'(flags_q) & 'h0811, 0);

    req = "R9";
    load('h0001);
    op(3, 1, 'h7FFF, 'h0000);
    check("R9 inc keeps cf", int'(flags_q) & 1, 1);
    op(4, 0, 'h0080, 'h1234);
    op(3, 1, 'hFFFF, 'h0000);
    load('h0000);
    op(4, 1, 'h0000, 'h0000);
    check("R9 dec keeps cf clear", int'(flags_q) & 1, 0);

    req = "R10";
    ctl(0, 1); ctl(1, 1); ctl(2, 1);
    check("R10 all control set", int'(flags_q) & 'h0700, 'h0700);
    check("R11 dir down", int'(dir_down), 1);
    ctl(3, 0);
    ctl(1, 0); ctl(2, 0);
    upd_en = 1; opc = 0; wsel = 1; opa = 1; opb = 1; res = 2;
    ctl_we = 1; ctl_sel = 2; ctl_val = 1; step();
    req = "R3";
    upd_en = 1; opc = 0; opa = 'hFFFF; opb = 1; res = 0;
    ctl_we = 1; ctl_sel = 0; ctl_val = 0; wr_en = 1; wr_data = 'h0400; step();
    check("R3 load wins", int'(flags_q), 'h0402);

    req = "R12";
    repeat (3) step();
    upd_en = 1; opc = 5; opa = 'hFFFF; opb = 1; res = 0; step();
    upd_en = 1; opc = 7; step();
    check("R12 hold", int'(flags_q), 'h0402);

    req = "R6";
    for (int i = 0; i < 400; i++) begin
      int k;
      k = int'($urandom % 8);
      if (k < 5) op(k, int'($urandom % 2), int'($urandom & 'hFFFF), int'($urandom & 'hFFFF));
      else if (k < 7) ctl(int'($urandom % 4), int'($urandom % 2));
      else load(int'($urandom & 'hFFFF));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule